// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Slave

This block is the device side of an 8-bit parallel microcontroller bus on a display controller. One static mode input picks the strobe protocol on the same pins. In the enable-strobe protocol, one pin is an enable pulse and the other is a read/write level. In the split-strobe protocol, the two pins are separate active-low read and write strobes. Both protocols use an active-low chip select and a data/command select. All bus inputs are brought into the core clock through a two-flop synchronizer, and bus edges are detected in the core clock domain. The host must hold each strobe level for at least three core clocks.

Each completed write produces a one-cycle command strobe or a one-cycle display RAM write, with the byte on `wrByte`. A display RAM write goes to the current column pointer, and the pointer then steps forward. Reads with the select low return a live status byte. Reads with the select high return display RAM data through a one-stage pipeline. After each data read completes, the block fetches the next byte from RAM. Because of this, the first data read after reset or after a column load returns a dummy byte. The external command decoder loads the column pointer through `colLoad`/`colValue`. The bus is driven only while a read is in progress.

Top module: `dual_host_bus`

## Requirements
- R1: In enable-strobe mode (`modeSel`=0), a falling edge of `enRd` while `csN`=0 and `rwWr`=0 completes a write. `dcN`=0 makes it a command write: `cmdStrobe` pulses with the byte on `wrByte`. `dcN`=1 makes it a data write: `ramWe` pulses with the byte on `wrByte`.
- R2: While `csN`=1, strobe activity produces no command strobe, no RAM write and no bus drive.
- R3: In split-strobe mode (`modeSel`=1), a rising edge of `rwWr` (write strobe, active low) while `csN`=0 completes a write, decoded by `dcN` as in R1.
- R4: In split-strobe mode, a rising edge of `enRd` (read strobe, active low) while `csN`=0 completes a read.
- R5: `dataOe` is 1 only while `csN`=0 and a read is active. In enable-strobe mode that means `enRd`=1 and `rwWr`=1. In split-strobe mode it means `enRd`=0. At all other times `dataOe` is 0, including during writes.
- R6: During a read with `dcN`=0, `dataOut` equals `statusIn`, and that read leaves the column pointer unchanged.
- R7: A data write stores its byte at RAM address equal to the column pointer, then increments the pointer by one.
- R8: The column pointer wraps from 127 to 0 after a data access.
- R9: During a read with `dcN`=1, `dataOut` shows the pipeline byte. Each completed data read fetches RAM at the pointer into the pipeline and increments the pointer. After a load to column c, reads therefore return 0x00 (dummy), RAM[c], RAM[c+1], and so on.
- R10: A column load clears the pipeline to the dummy byte 0x00 and discards any fetch in flight.
- R11: After reset, all strobes are 0, `dataOe` is 0, the column pointer is 0 and the pipeline holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0 = enable-strobe protocol, 1 = split-strobe protocol |
| csN | input | 1 | Chip select, active low |
| dcN | input | 1 | 0 = command/status, 1 = display data |
| enRd | input | 1 | Enable (mode 0) or read strobe, active low (mode 1) |
| rwWr | input | 1 | Read/write level, 1 = read (mode 0), or write strobe, active low (mode 1) |
| dataIn | input | 8 | Bus data from host |
| dataOut | output | 8 | Bus data to host |
| dataOe | output | 1 | Bus output enable |
| statusIn | input | 8 | Status byte returned on command-side reads |
| colLoad | input | 1 | Column pointer load pulse from command decoder |
| colValue | input | 7 | Column value to load |
| cmdStrobe | output | 1 | One-cycle command byte strobe |
| ramWe | output | 1 | One-cycle display RAM write (data byte strobe) |
| ramRe | output | 1 | One-cycle display RAM read request |
| ramAddr | output | 7 | Display RAM address |
| wrByte | output | 8 | Written byte for command strobe and RAM write |
| ramRdata | input | 8 | Display RAM read data, one cycle after `ramRe` |

## Verification
The hardest case to reach is the interaction between the read pipeline and the pointer. A status read placed between two data reads must neither consume nor refill the pipeline. Wrap-around must also appear both on the write side and on the fetch side. The stimulus loads a column, writes known bytes across the 127-to-0 boundary, reloads the column, and then reads back. It expects the dummy byte first and then the written bytes in order, with a status read inserted partway through. The same sequences run in both protocols, including strobes with the chip deselected.

// File: rtl/dual_host_bus_pkg.sv
package dual_host_bus_pkg;

  // Bus events decoded in the core clock domain, one cycle wide each.
  typedef struct packed {
    logic cmdWr;
    logic dataWr;
    logic dataRd;
    logic statRd;
  } bus_evt_t;

endpackage

// File: rtl/dhb_ctrl.sv
module dhb_ctrl
  import dual_host_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              csN,
  input  logic              dcN,
  input  logic              enRd,
  input  logic              rwWr,
  input  logic [DATA_W-1:0] dataIn,
  output bus_evt_t          evt,
  output logic [DATA_W-1:0] evtByte,
  output logic              busOe,
  output logic              dcNow
);

  localparam int VEC_W = DATA_W + 4;
  localparam int CS_B  = DATA_W + 3;
  localparam int DC_B  = DATA_W + 2;
  localparam int ER_B  = DATA_W + 1;
  localparam int RW_B  = DATA_W;

  logic [VEC_W-1:0] rawVec;
  logic [VEC_W-1:0] idleVec;
  logic [SYNC_STAGES-1:0][VEC_W-1:0] chain;
  logic [VEC_W-1:0] nowVec;
  logic [VEC_W-1:0] prevQ;

  assign rawVec  = {csN, dcN, enRd, rwWr, dataIn};
  // Idle strobe levels: the enable idles low, the read strobe idles high.
  assign idleVec = {1'b1, 1'b1, modeSel, 1'b1, {DATA_W{1'b0}}};

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chain[i] <= idleVec;
        end else begin
          if (i == 0) chain[i] <= rawVec;
          else        chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign nowVec = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= idleVec;
    else       prevQ <= nowVec;
  end

  logic csPrev, dcPrev, rwPrev;
  logic eFall, wrRise, rdRise;
  logic isWrite, isRead;

  always_comb begin
    csPrev = ~prevQ[CS_B];
    dcPrev = prevQ[DC_B];
    rwPrev = prevQ[RW_B];
    eFall  = prevQ[ER_B] & ~nowVec[ER_B];
    wrRise = ~prevQ[RW_B] & nowVec[RW_B];
    rdRise = ~prevQ[ER_B] & nowVec[ER_B];
    if (modeSel) begin
      isWrite = wrRise & csPrev;
      isRead  = rdRise & csPrev & ~wrRise;
    end else begin
      isWrite = eFall & csPrev & ~rwPrev;
      isRead  = eFall & csPrev & rwPrev;
    end
    evt.cmdWr  = isWrite & ~dcPrev;
    evt.dataWr = isWrite & dcPrev;
    evt.dataRd = isRead & dcPrev;
    evt.statRd = isRead & ~dcPrev;
    evtByte    = prevQ[DATA_W-1:0];
  end

  always_comb begin
    if (nowVec[CS_B]) busOe = 1'b0;
    else if (modeSel) busOe = ~nowVec[ER_B];
    else              busOe = nowVec[ER_B] & nowVec[RW_B];
    dcNow = nowVec[DC_B];
  end

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (evt.cmdWr || evt.dataWr) |-> !busOe); // R5

endmodule

// File: rtl/dhb_datapath.sv
module dhb_datapath
  import dual_host_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COLS   = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bus_evt_t                 evt,
  input  logic [DATA_W-1:0]        evtByte,
  input  logic                     busOe,
  input  logic                     dcNow,
  input  logic [DATA_W-1:0]        statusIn,
  input  logic                     colLoad,
  input  logic [$clog2(COLS)-1:0]  colValue,
  input  logic [DATA_W-1:0]        ramRdata,
  output logic                     cmdStrobe,
  output logic                     ramWe,
  output logic                     ramRe,
  output logic [$clog2(COLS)-1:0]  ramAddr,
  output logic [DATA_W-1:0]        wrByte,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataOe
);

  localparam int COL_W = $clog2(COLS);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(COLS - 1);

  logic [COL_W-1:0]  colPtr;
  logic [COL_W-1:0]  colNext;
  logic [DATA_W-1:0] pipeQ;
  logic              fillQ;
  logic              access;

  assign access  = evt.dataWr | evt.dataRd;
  assign colNext = (colPtr == COL_MAX) ? '0 : colPtr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdStrobe <= 1'b0;
      ramWe     <= 1'b0;
      ramRe     <= 1'b0;
      ramAddr   <= '0;
      wrByte    <= '0;
      colPtr    <= '0;
    end else begin
      cmdStrobe <= evt.cmdWr;
      ramWe     <= evt.dataWr & ~colLoad;
      ramRe     <= evt.dataRd & ~colLoad;
      if (evt.cmdWr || evt.dataWr) wrByte <= evtByte;
      if (access) ramAddr <= colPtr;
      if (colLoad)     colPtr <= colValue;
      else if (access) colPtr <= colNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ <= '0;
      fillQ <= 1'b0;
    end else if (colLoad) begin
      pipeQ <= '0;
      fillQ <= 1'b0;
    end else begin
      fillQ <= ramRe;
      if (fillQ) pipeQ <= ramRdata;
    end
  end

  assign dataOut = dcNow ? pipeQ : statusIn;
  assign dataOe  = busOe;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evt.cmdWr, evt.dataWr, evt.dataRd, evt.statRd})); // R1
  AST_WRITE_AT_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (evt.dataWr && !colLoad) |=> (ramWe && ramAddr == $past(colPtr))); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (access && !colLoad && colPtr == COL_MAX) |=> (colPtr == '0)); // R8
  AST_DUMMY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    colLoad |=> (pipeQ == '0 && !fillQ)); // R10
  AST_STATUS_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (evt.statRd && !colLoad) |=> $stable(colPtr)); // R6

endmodule

// File: rtl/dual_host_bus.sv
module dual_host_bus
  import dual_host_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int COLS        = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     modeSel,
  input  logic                     csN,
  input  logic                     dcN,
  input  logic                     enRd,
  input  logic                     rwWr,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataOe,
  input  logic [DATA_W-1:0]        statusIn,
  input  logic                     colLoad,
  input  logic [$clog2(COLS)-1:0]  colValue,
  output logic                     cmdStrobe,
  output logic                     ramWe,
  output logic                     ramRe,
  output logic [$clog2(COLS)-1:0]  ramAddr,
  output logic [DATA_W-1:0]        wrByte,
  input  logic [DATA_W-1:0]        ramRdata
);

  bus_evt_t          evt;
  logic [DATA_W-1:0] evtByte;
  logic              busOe;
  logic              dcNow;

  dhb_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .dcN(dcN),
    .enRd(enRd), .rwWr(rwWr), .dataIn(dataIn), .evt(evt),
    .evtByte(evtByte), .busOe(busOe), .dcNow(dcNow)
  );

  dhb_datapath #(.DATA_W(DATA_W), .COLS(COLS)) u_dp (
    .clk(clk), .rstN(rstN), .evt(evt), .evtByte(evtByte), .busOe(busOe),
    .dcNow(dcNow), .statusIn(statusIn), .colLoad(colLoad),
    .colValue(colValue), .ramRdata(ramRdata), .cmdStrobe(cmdStrobe),
    .ramWe(ramWe), .ramRe(ramRe), .ramAddr(ramAddr), .wrByte(wrByte),
    .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: tb/dual_host_bus_test.sv
`timescale 1ns/1ps
module dual_host_bus_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSel = 1'b0;
  logic       csN = 1'b1, dcN = 1'b1, enRd = 1'b0, rwWr = 1'b1;
  logic [7:0] dataIn = '0, statusIn = '0;
  logic       colLoad = 1'b0;
  logic [6:0] colValue = '0;
  logic [7:0] dataOut, wrByte;
  logic       dataOe, cmdStrobe, ramWe, ramRe;
  logic [6:0] ramAddr;
  logic [7:0] ramRdata = '0;
  logic [7:0] mem [128];

  int checks = 0;
  int errors = 0;
  int expPtr = 0;

  typedef struct {
    bit         isData;
    logic [7:0] byt;
    logic [6:0] adr;
    string      req;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  dual_host_bus uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .dcN(dcN),
    .enRd(enRd), .rwWr(rwWr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .statusIn(statusIn), .colLoad(colLoad),
    .colValue(colValue), .cmdStrobe(cmdStrobe), .ramWe(ramWe),
    .ramRe(ramRe), .ramAddr(ramAddr), .wrByte(wrByte), .ramRdata(ramRdata)
  );

  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= wrByte;
    if (ramRe) ramRdata <= mem[ramAddr];
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected strobes as the design produces them.
  always @(negedge clk) begin
    if (rstN && (cmdStrobe || ramWe)) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2", "unexpected strobe", {cmdStrobe, ramWe}, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(ramWe == e.isData && cmdStrobe == !e.isData, e.req, "strobe kind",
            {cmdStrobe, ramWe}, e.isData ? 1 : 2);
        chk(wrByte == e.byt, e.req, "written byte", wrByte, e.byt);
        if (e.isData) chk(ramAddr == e.adr, e.req, "ram address", ramAddr, e.adr);
      end
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busIdle();
    csN = 1'b1; rwWr = 1'b1; enRd = modeSel;
  endtask

  task automatic busWrite(bit dc, logic [7:0] b, string req, bit sel = 1'b1);
    if (sel) begin
      exp_t e;
      e.isData = dc; e.byt = b; e.adr = expPtr[6:0]; e.req = req;
      expQ.push_back(e);
      if (dc) expPtr = (expPtr + 1) % 128;
    end
    csN = ~sel; dcN = dc; dataIn = b; rwWr = 1'b0;
    if (!modeSel) enRd = 1'b1;
    waitClk(5);
    chk(dataOe == 1'b0, "R5", "no drive during write", dataOe, 0);
    if (modeSel) rwWr = 1'b1; else enRd = 1'b0;
    waitClk(5);
    busIdle();
    waitClk(3);
  endtask

  task automatic busRead(bit dc, logic [7:0] exp, string req, bit sel = 1'b1);
    csN = ~sel; dcN = dc;
    if (modeSel) enRd = 1'b0; else begin rwWr = 1'b1; enRd = 1'b1; end
    waitClk(5);
    chk(dataOe == sel, "R5", "output enable during read", dataOe, sel);
    if (sel) chk(dataOut == exp, req, "read byte", dataOut, exp);
    if (modeSel) enRd = 1'b1; else enRd = 1'b0;
    waitClk(5);
    chk(dataOe == 1'b0, "R5", "output enable after read", dataOe, 0);
    busIdle();
    if (sel && dc) expPtr = (expPtr + 1) % 128;
    waitClk(3);
  endtask

  task automatic loadCol(int v);
    colLoad = 1'b1; colValue = v[6:0];
    waitClk(1);
    colLoad = 1'b0;
    expPtr = v;
    waitClk(2);
  endtask

  task automatic doReset(bit mode);
    rstN = 1'b0; modeSel = mode; busIdle(); expPtr = 0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    chk(!dataOe && !cmdStrobe && !ramWe && !ramRe, "R11", "idle outputs",
        {dataOe, cmdStrobe, ramWe, ramRe}, 0);
  endtask

  task automatic runSuite(bit mode);
    string wreq;
    string rreq;
    wreq = mode ? "R3" : "R1";
    rreq = mode ? "R4" : "R9";
    doReset(mode);
    // R11: pipeline holds dummy 0x00 and pointer starts at 0
    busRead(1'b1, 8'h00, "R11");
    expPtr = 0;
    loadCol(0);
    busWrite(1'b0, mode ? 8'h21 : 8'hAE, wreq);
    busWrite(1'b1, 8'h11, "R11");
    loadCol(5);
    busWrite(1'b1, 8'hA1, "R7");
    busWrite(1'b1, 8'hB2, wreq);
    busWrite(1'b1, 8'hC3, "R7");
    statusIn = 8'h5A;
    busRead(1'b0, 8'h5A, "R6");
    statusIn = 8'h3C;
    busRead(1'b0, 8'h3C, "R6");
    loadCol(5);
    busRead(1'b1, 8'h00, "R9");
    busRead(1'b0, 8'h3C, "R6");
    busRead(1'b1, 8'hA1, rreq);
    busRead(1'b1, 8'hB2, "R6");
    busRead(1'b1, 8'hC3, "R9");
    // R10: reload discards the filled pipeline
    loadCol(5);
    busRead(1'b1, 8'h00, "R10");
    busRead(1'b1, 8'hA1, "R10");
    // R2: deselected strobes have no effect
    busWrite(1'b0, 8'h77, "R2", 1'b0);
    busWrite(1'b1, 8'h78, "R2", 1'b0);
    busRead(1'b1, 8'h00, "R2", 1'b0);
    chk(expQ.size() == 0, "R2", "pending strobes", expQ.size(), 0);
    busRead(1'b1, 8'hB2, "R2");
    // R8: wrap from 127 to 0 on writes and fetches
    loadCol(127);
    busWrite(1'b1, mode ? 8'hF1 : 8'hE1, "R8");
    busWrite(1'b1, mode ? 8'hF2 : 8'hE2, "R8");
    loadCol(127);
    busRead(1'b1, 8'h00, "R8");
    busRead(1'b1, mode ? 8'hF1 : 8'hE1, "R8");
    busRead(1'b1, mode ? 8'hF2 : 8'hE2, "R8");
    chk(expQ.size() == 0, "R7", "all writes seen", expQ.size(), 0);
  endtask

  initial begin
    runSuite(1'b0);
    runSuite(1'b1);
    waitClk(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule